// File: doc/BRIEF.md
# Latching Non-Deferrable Watchdog

This block is a one-shot watchdog that cannot be stopped once started. Before it is armed, software programs a 32-bit delay, counted in enabled clock cycles, and then sets the arm bit. From that point the countdown cannot be turned off, slowed, refilled or reprogrammed by any write. When the count runs out, the block raises a platform reset request. It does this whether the system is hung or healthy, so a recovery routine is certain to run on a fixed schedule.

The remaining count is always visible on an output, so software can finish its work before the reset arrives. The reset request stays high until the platform reset comes back to the block. That reset is the only thing that clears the armed state.

The register interface is a single write port. `wrSel` = 0 selects the control register, where bit 0 of `wrData` is the arm bit. `wrSel` = 1 selects the timeout register, which takes all 32 bits. The `tickEn` input lets an external prescaler set how fast the counter runs.

Top module: `latch_wdt`

## Requirements
- R1: While `rstN` is low and in the first cycle after it is released, `armed`, `resetReq` and `writeIgnored` read 0, and `remainCount` and `cfgTimeout` read 0.
- R2: While unarmed, a write with `wrSel`=1 stores `wrData` into the timeout register, and the new value shows on `cfgTimeout` after the next clock edge. A control write with bit 0 = 0 does not arm the block.
- R3: While unarmed, a control write (`wrSel`=0) with bit 0 = 1 sets `armed` and loads `remainCount` from the timeout register, and both are visible after that same clock edge.
- R4: While armed, `remainCount` falls by exactly one at each clock edge where `tickEn` is 1 and the count is nonzero. It holds its value when `tickEn` is 0.
- R5: A timeout value of 0 loads the maximum count, 0xFFFFFFFF, on arming, so arming never produces an immediate reset.
- R6: Once armed and `remainCount` reaches 0, `resetReq` goes high in that same cycle. It then stays high, with `remainCount` held at 0, until `rstN` is asserted.
- R7: While armed, control writes are ignored. This covers a disable (bit 0 = 0) and a re-arm (bit 0 = 1). `armed` stays 1 and `remainCount` is neither reloaded nor paused.
- R8: While armed, timeout writes are ignored. `cfgTimeout` keeps its value and `remainCount` is not reloaded.
- R9: Any write while armed sets `writeIgnored`. The flag stays set until `rstN` is asserted.
- R10: Only `rstN` clears `armed`. After the reset, the block can be programmed and armed again with a new delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low platform reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0 = control register (bit 0 arm), 1 = timeout register |
| wrData | input | 32 | Write data |
| tickEn | input | 1 | Prescaler enable; the counter steps only when this is high |
| armed | output | 1 | Watchdog armed |
| resetReq | output | 1 | Platform reset request, held until reset |
| writeIgnored | output | 1 | Sticky flag: a write was refused while armed |
| remainCount | output | 32 | Remaining count |
| cfgTimeout | output | 32 | Programmed timeout register |

## Verification
Some behaviours are checked by the in-RTL assertions on every cycle:
- `armed` never falls without a reset.
- `resetReq` and `writeIgnored` never drop once set.
- The count never rises except on a load.
- A load always leaves a nonzero count.
- The timeout register never changes outside an accepted write.

Other behaviours only the bench scenarios can show:
- That exact delays expire on the right edge.
- The substitution of the maximum count for a zero timeout.
- The holding of the count when `tickEn` is low.
- That disable, re-arm and reprogram attempts leave the observable count untouched.

// File: rtl/lwdt_pkg.sv
package lwdt_pkg;
  localparam int unsigned CNT_W = 32;

  // strobes from control to datapath
  typedef struct packed {
    logic writeTimeout;
    logic loadCount;
    logic decCount;
  } wdStrobe_t;
endpackage

// File: rtl/lwdt_ctrl.sv
module lwdt_ctrl
  import lwdt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  logic      wrSel,
  input  logic      wrArm,
  input  logic      tickEn,
  input  logic      countZero,
  output wdStrobe_t strobe,
  output logic      armed,
  output logic      writeIgnored,
  output logic      resetReq
);
  logic ctrlWrite;
  logic timeoutWrite;

  assign ctrlWrite    = wrEn && !wrSel;
  assign timeoutWrite = wrEn && wrSel;

  always_comb begin
    strobe.writeTimeout = !armed && timeoutWrite;
    strobe.loadCount    = !armed && ctrlWrite && wrArm;
    strobe.decCount     = armed && tickEn && !countZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed        <= 1'b0;
      writeIgnored <= 1'b0;
    end else begin
      if (strobe.loadCount) armed <= 1'b1;
      if (armed && wrEn)    writeIgnored <= 1'b1;
    end
  end

  assign resetReq = armed && countZero;

  assert_arm_latched_R10: assert property (@(posedge clk) disable iff (!rstN)
    armed |=> armed);
  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> resetReq);
  assert_ignored_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (armed && wrEn) |=> writeIgnored);
  assert_ignored_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    writeIgnored |=> writeIgnored);
  assert_no_load_when_armed_R7: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> !strobe.loadCount && !strobe.writeTimeout);
endmodule

// File: rtl/lwdt_datapath.sv
module lwdt_datapath
  import lwdt_pkg::*;
#(
  parameter int unsigned WIDTH = CNT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobe_t        strobe,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] timeoutReg,
  output logic [WIDTH-1:0] count,
  output logic             countZero
);
  localparam logic [WIDTH-1:0] MAX_COUNT = '1;

  logic [WIDTH-1:0] loadValue;

  assign loadValue = (timeoutReg == '0) ? MAX_COUNT : timeoutReg;
  assign countZero = (count == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeoutReg <= '0;
      count      <= '0;
    end else begin
      if (strobe.writeTimeout) timeoutReg <= wrData;
      if (strobe.loadCount)     count <= loadValue;
      else if (strobe.decCount) count <= count - 1'b1;
    end
  end

  assert_load_nonzero_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCount |=> (count != '0));
  assert_no_growth_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadCount |=> (count <= $past(count)));
  assert_timeout_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.writeTimeout |=> $stable(timeoutReg));
endmodule

// File: rtl/latch_wdt.sv
module latch_wdt
  import lwdt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              tickEn,
  output logic              armed,
  output logic              resetReq,
  output logic              writeIgnored,
  output logic [CNT_W-1:0]  remainCount,
  output logic [CNT_W-1:0]  cfgTimeout
);
  wdStrobe_t strobe;
  logic      countZero;

  lwdt_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .wrSel        (wrSel),
    .wrArm        (wrData[0]),
    .tickEn       (tickEn),
    .countZero    (countZero),
    .strobe       (strobe),
    .armed        (armed),
    .writeIgnored (writeIgnored),
    .resetReq     (resetReq)
  );

  lwdt_datapath #(.WIDTH(CNT_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (wrData),
    .timeoutReg (cfgTimeout),
    .count      (remainCount),
    .countZero  (countZero)
  );
endmodule

// File: tb/latch_wdt_tb_top.sv
`timescale 1ns/1ps
module latch_wdt_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [31:0] wrData = '0;
  logic        tickEn = 1'b0;
  logic        armed, resetReq, writeIgnored;
  logic [31:0] remainCount, cfgTimeout;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  latch_wdt dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .tickEn(tickEn), .armed(armed), .resetReq(resetReq),
    .writeIgnored(writeIgnored), .remainCount(remainCount), .cfgTimeout(cfgTimeout)
  );

  typedef struct packed {
    logic [31:0] timeout;
    logic [31:0] expLoad;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{32'd1,  32'd1},
    '{32'd2,  32'd2},
    '{32'd7,  32'd7},
    '{32'd23, 32'd23},
    '{32'd0,  32'hFFFF_FFFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    wrEn = 1'b0;
    tickEn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic doWrite(input logic sel, input logic [31:0] data);
    @(negedge clk);
    wrEn = 1'b1;
    wrSel = sel;
    wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runTicks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 armed", {31'd0, armed}, 32'd0);
    check("R1 resetReq", {31'd0, resetReq}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ignored", {31'd0, writeIgnored}, 32'd0);
    check("R1 count", remainCount, 32'd0);
    check("R1 timeout", cfgTimeout, 32'd0);

    // vector table: program, arm, run to expiry
    for (int i = 0; i < NVEC; i++) begin
      doReset();
      doWrite(1'b1, VECS[i].timeout);
      check("R2 timeout write", cfgTimeout, VECS[i].timeout);
      doWrite(1'b0, 32'd1);
      check("R3 armed", {31'd0, armed}, 32'd1);
      check("R3/R5 load", remainCount, VECS[i].expLoad);
      if (VECS[i].expLoad < 32'd100) begin
        runTicks(int'(VECS[i].expLoad) - 1);
        check("R4 count one", remainCount, 32'd1);
        check("R6 not yet", {31'd0, resetReq}, 32'd0);
        runTicks(1);
        check("R6 expire count", remainCount, 32'd0);
        check("R6 fire", {31'd0, resetReq}, 32'd1);
        runTicks(3);
        check("R6 held", {31'd0, resetReq}, 32'd1);
        check("R6 count held", remainCount, 32'd0);
      end else begin
        runTicks(3);
        check("R5 max decrement", remainCount, 32'hFFFF_FFFC);
        check("R5 no fire", {31'd0, resetReq}, 32'd0);
      end
    end

    // R2: disarm-style write while unarmed does not arm
    doReset();
    doWrite(1'b0, 32'd0);
    check("R2 no arm", {31'd0, armed}, 32'd0);
    check("R2 no ignore", {31'd0, writeIgnored}, 32'd0);

    // R4: tickEn low holds
    doWrite(1'b1, 32'd10);
    doWrite(1'b0, 32'd1);
    repeat (5) @(negedge clk);
    check("R4 hold", remainCount, 32'd10);

    // R7: disable attempt ignored
    doWrite(1'b0, 32'd0);
    check("R7 still armed", {31'd0, armed}, 32'd1);
    check("R7 count kept", remainCount, 32'd10);
    check("R9 ignored set", {31'd0, writeIgnored}, 32'd1);

    // R8: reprogram ignored
    doWrite(1'b1, 32'd99);
    check("R8 timeout kept", cfgTimeout, 32'd10);
    check("R8 no reload", remainCount, 32'd10);

    // R7: re-arm does not restart
    runTicks(4);
    doWrite(1'b0, 32'd1);
    check("R7 no restart", remainCount, 32'd6);

    // R7: writing while ticking does not pause
    @(negedge clk);
    tickEn = 1'b1;
    wrEn = 1'b1;
    wrSel = 1'b0;
    wrData = 32'd0;
    repeat (2) @(negedge clk);
    wrEn = 1'b0;
    tickEn = 1'b0;
    check("R7 no pause", remainCount, 32'd4);
    check("R9 still set", {31'd0, writeIgnored}, 32'd1);

    // R10: reset clears and allows reprogramming
    doReset();
    @(negedge clk);
    check("R10 disarmed", {31'd0, armed}, 32'd0);
    check("R9 cleared", {31'd0, writeIgnored}, 32'd0);
    doWrite(1'b1, 32'd3);
    doWrite(1'b0, 32'd1);
    check("R10 rearm load", remainCount, 32'd3);
    runTicks(3);
    check("R10 fire again", {31'd0, resetReq}, 32'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule